// File: doc/BRIEF.md
# Unlock Sequence Decoder for a Page-Write Memory

This block sits on the write side of a byte-wide, page-programmed nonvolatile memory. It observes every bus write cycle (address plus data byte) and decides what that cycle means: the next step of an unlock sequence, page data that may go on to the page loader, or a stray write that must be refused. Recognised sequences switch the global write protection on or off, start a whole-array erase, or move reads into an identification mode where two fixed bytes replace array data.

All sequences begin with the same two key writes and then branch on a command byte written to the first key address. A short form acts on that command byte at once. A long form, selected by one particular command byte, repeats the two key writes and acts on a final byte. A permitted page load stays open until the page loader reports that its load window has closed. While protection is on, a write that arrives without the unlock prefix is refused and the write port then ignores everything for a fixed number of clock cycles.

Top module: `seq_guard`

## Requirements
- R1: After reset, protection is off, identification mode is off, the lockout flag is low, and none of the four pulse outputs is high.
- R2: Command addresses are matched on address bits 14..0 only; bits 16..15 of both the write address and the read address have no effect.
- R3: The writes AAh at 5555h, 55h at 2AAAh, A0h at 5555h give one `permit_o` pulse and set `prot_en_o`. Every later write is then forwarded with a `pass_o` pulse, and is not decoded, until `page_done_i` is seen.
- R4: The long form (AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then a final byte at 5555h) with final byte 20h clears `prot_en_o`.
- R5: The long form with final byte 10h gives one `erase_o` pulse and leaves `prot_en_o` unchanged.
- R6: The short form with command byte 90h and the long form with final byte 60h set `id_mode_o`; the short form with command byte F0h clears it.
- R7: With `id_mode_o` high and read address bits 14..1 all zero, `id_hit_o` is high and `id_data_o` is BFh when bit 0 is 0 and `DEV_CODE` when bit 0 is 1. Any other read address, or identification mode off, gives `id_hit_o` low.
- R8: With protection off and no sequence in progress, a write that is not AAh at 5555h gives one `pass_o` pulse.
- R9: With protection on and no sequence in progress, a write that is not AAh at 5555h gives one `reject_o` pulse and raises `locked_o` for exactly `LOCK_CYCLES` cycles. Writes made during lockout change no state and give no pulse.
- R10: A write that does not match the next expected step of a sequence is consumed with no pulse and no state change. The decoder returns to idle, so the following write is decoded as if it came first.
- R11: Each write produces at most one of `permit_o`, `erase_o`, `pass_o` and `reject_o`. A pulse appears only in the cycle that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One write cycle is presented this clock |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| page_done_i | input | 1 | Page loader reports its load window has closed |
| rd_addr | input | AW | Read address, used for identification lookup |
| prot_en_o | output | 1 | Global write protection is on |
| id_mode_o | output | 1 | Reads are redirected to identification bytes |
| permit_o | output | 1 | Pulse: protected page load opened |
| erase_o | output | 1 | Pulse: start whole-array erase |
| pass_o | output | 1 | Pulse: this write goes to the page loader |
| reject_o | output | 1 | Pulse: unprotected-style write refused |
| locked_o | output | 1 | Write port is in its post-reject lockout |
| id_hit_o | output | 1 | Read address selects an identification byte |
| id_data_o | output | 8 | Identification byte for the read address |

## Verification
On every cycle the assertions check that the pulses are mutually exclusive and follow a write, that protection only rises together with a permit and only falls after a write, that a reject comes only from a protected state and always starts the lockout, that nothing moves while the port is locked, and that identification hits occur only in identification mode. Only the bench's scenarios can show that each command byte selects the right operation. They also show that the high address bits are ignored, that a broken sequence is consumed and leaves the next write decoded from the start, that the lockout lasts exactly its set length, and that the read bytes have the right values.

// File: rtl/seq_guard_pkg.sv
package seq_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_EXT3,
    ST_EXT4,
    ST_EXT5,
    ST_LOAD
  } seq_st_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PERMIT,
    ACT_ERASE,
    ACT_PROT_OFF,
    ACT_ID_ON,
    ACT_ID_OFF,
    ACT_PASS,
    ACT_REJECT
  } seq_act_t;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_B = 8'h55;

  localparam logic [7:0]  CMD_PAGE    = 8'hA0;
  localparam logic [7:0]  CMD_EXTEND  = 8'h80;
  localparam logic [7:0]  CMD_ID_IN   = 8'h90;
  localparam logic [7:0]  CMD_ID_OUT  = 8'hF0;
  localparam logic [7:0]  XCMD_UNPROT = 8'h20;
  localparam logic [7:0]  XCMD_ERASE  = 8'h10;
  localparam logic [7:0]  XCMD_ID_IN  = 8'h60;

  localparam logic [7:0]  MFR_CODE    = 8'hBF;

endpackage

// File: rtl/seq_key_match.sv
module seq_key_match #(
  parameter int CMP_BITS = 15
) (
  input  logic [CMP_BITS-1:0] addr,
  input  logic [7:0]          data,
  output logic                at_key_a,
  output logic                first_ok,
  output logic                second_ok
);
  import seq_guard_pkg::*;

  logic at_key_b;

  always_comb begin
    at_key_a  = (addr == CMP_BITS'(KEY_ADDR_A));
    at_key_b  = (addr == CMP_BITS'(KEY_ADDR_B));
    first_ok  = at_key_a && (data == KEY_BYTE_A);
    second_ok = at_key_b && (data == KEY_BYTE_B);
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    at_key_a,
  input  logic                    first_ok,
  input  logic                    second_ok,
  input  logic [7:0]              data,
  input  logic                    prot_on,
  input  logic                    page_done,
  output seq_guard_pkg::seq_act_t act
);
  import seq_guard_pkg::*;

  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    act  = ACT_NONE;
    if (st_q == ST_LOAD) begin
      if (page_done) begin
        st_d = ST_IDLE;
      end
      if (wr) begin
        act = ACT_PASS;
      end
    end else if (wr) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE: begin
          if (first_ok) begin
            st_d = ST_KEY1;
          end else begin
            act = prot_on ? ACT_REJECT : ACT_PASS;
          end
        end
        ST_KEY1: if (second_ok) st_d = ST_KEY2;
        ST_KEY2: begin
          if (at_key_a) begin
            case (data)
              CMD_PAGE: begin
                act  = ACT_PERMIT;
                st_d = ST_LOAD;
              end
              CMD_EXTEND: st_d = ST_EXT3;
              CMD_ID_IN:  act  = ACT_ID_ON;
              CMD_ID_OUT: act  = ACT_ID_OFF;
              default:    act  = ACT_NONE;
            endcase
          end
        end
        ST_EXT3: if (first_ok) st_d = ST_EXT4;
        ST_EXT4: if (second_ok) st_d = ST_EXT5;
        ST_EXT5: begin
          if (at_key_a) begin
            case (data)
              XCMD_UNPROT: act = ACT_PROT_OFF;
              XCMD_ERASE:  act = ACT_ERASE;
              XCMD_ID_IN:  act = ACT_ID_ON;
              default:     act = ACT_NONE;
            endcase
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/seq_lockout.sv
module seq_lockout #(
  parameter int LOCK_CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CW'(LOCK_CYCLES) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign locked = (cnt_q != '0);

endmodule

// File: rtl/seq_id_rom.sv
module seq_id_rom #(
  parameter int          CMP_BITS = 15,
  parameter logic [7:0]  DEV_CODE = 8'h07
) (
  input  logic                id_mode,
  input  logic [CMP_BITS-1:0] addr,
  output logic                hit,
  output logic [7:0]          data
);
  import seq_guard_pkg::*;

  always_comb begin
    hit  = id_mode && (addr[CMP_BITS-1:1] == '0);
    data = addr[0] ? DEV_CODE : MFR_CODE;
  end

endmodule

// File: rtl/seq_guard.sv
module seq_guard #(
  parameter int         AW          = 17,
  parameter int         CMP_BITS    = 15,
  parameter logic [7:0] DEV_CODE    = 8'h07,
  parameter int         LOCK_CYCLES = 15000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          page_done_i,
  input  logic [AW-1:0] rd_addr,
  output logic          prot_en_o,
  output logic          id_mode_o,
  output logic          permit_o,
  output logic          erase_o,
  output logic          pass_o,
  output logic          reject_o,
  output logic          locked_o,
  output logic          id_hit_o,
  output logic [7:0]    id_data_o
);
  import seq_guard_pkg::*;

  logic     unused_hi_bits;
  logic     wr_live;
  logic     at_key_a, first_ok, second_ok;
  seq_act_t act;

  logic prot_d, idm_d;
  logic permit_d, erase_d, pass_d, reject_d;

  assign unused_hi_bits = ^{wr_addr[AW-1:CMP_BITS], rd_addr[AW-1:CMP_BITS]};
  assign wr_live        = wr_valid && !locked_o;

  seq_key_match #(.CMP_BITS(CMP_BITS)) u_match (
    .addr      (wr_addr[CMP_BITS-1:0]),
    .data      (wr_data),
    .at_key_a  (at_key_a),
    .first_ok  (first_ok),
    .second_ok (second_ok)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_live),
    .at_key_a  (at_key_a),
    .first_ok  (first_ok),
    .second_ok (second_ok),
    .data      (wr_data),
    .prot_on   (prot_en_o),
    .page_done (page_done_i),
    .act       (act)
  );

  seq_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (reject_d),
    .locked (locked_o)
  );

  seq_id_rom #(.CMP_BITS(CMP_BITS), .DEV_CODE(DEV_CODE)) u_rom (
    .id_mode (id_mode_o),
    .addr    (rd_addr[CMP_BITS-1:0]),
    .hit     (id_hit_o),
    .data    (id_data_o)
  );

  always_comb begin
    prot_d   = prot_en_o;
    idm_d    = id_mode_o;
    permit_d = (act == ACT_PERMIT);
    erase_d  = (act == ACT_ERASE);
    pass_d   = (act == ACT_PASS);
    reject_d = (act == ACT_REJECT);
    case (act)
      ACT_PERMIT:   prot_d = 1'b1;
      ACT_PROT_OFF: prot_d = 1'b0;
      ACT_ID_ON:    idm_d  = 1'b1;
      ACT_ID_OFF:   idm_d  = 1'b0;
      default:      ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_en_o <= 1'b0;
      id_mode_o <= 1'b0;
      permit_o  <= 1'b0;
      erase_o   <= 1'b0;
      pass_o    <= 1'b0;
      reject_o  <= 1'b0;
    end else begin
      prot_en_o <= prot_d;
      id_mode_o <= idm_d;
      permit_o  <= permit_d;
      erase_o   <= erase_d;
      pass_o    <= pass_d;
      reject_o  <= reject_d;
    end
  end

endmodule

// File: rtl/seq_guard_chk.sv
module seq_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic prot_en,
  input logic id_mode,
  input logic permit,
  input logic erase,
  input logic pass,
  input logic reject,
  input logic locked,
  input logic id_hit
);
  logic any_pulse;
  assign any_pulse = permit | erase | pass | reject;

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({permit, erase, pass, reject})); // R11

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(wr_valid)); // R11

  AST_PROT_RISE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_en) |-> permit); // R3

  AST_PERMIT_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> prot_en); // R3

  AST_PROT_FALL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_en) |-> $past(wr_valid)); // R4

  AST_REJECT_FROM_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(prot_en)); // R9

  AST_REJECT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> locked); // R9

  AST_LOCK_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> reject); // R9

  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> (!any_pulse && $stable(prot_en) && $stable(id_mode))); // R9

  AST_ID_HIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> id_mode); // R7

endmodule

bind seq_guard seq_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .prot_en  (prot_en_o),
  .id_mode  (id_mode_o),
  .permit   (permit_o),
  .erase    (erase_o),
  .pass     (pass_o),
  .reject   (reject_o),
  .locked   (locked_o),
  .id_hit   (id_hit_o)
);

// File: tb/tb_seq_guard.sv
`timescale 1ns/1ps
module tb_seq_guard;
  localparam int         AW   = 17;
  localparam logic [7:0] DEV  = 8'h08;
  localparam int         LOCK = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          page_done_i;
  logic [AW-1:0] rd_addr;
  logic prot_en_o, id_mode_o, permit_o, erase_o, pass_o, reject_o, locked_o, id_hit_o;
  logic [7:0] id_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  seq_guard #(.AW(AW), .CMP_BITS(15), .DEV_CODE(DEV), .LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_done_i(page_done_i), .rd_addr(rd_addr),
    .prot_en_o(prot_en_o), .id_mode_o(id_mode_o), .permit_o(permit_o),
    .erase_o(erase_o), .pass_o(pass_o), .reject_o(reject_o),
    .locked_o(locked_o), .id_hit_o(id_hit_o), .id_data_o(id_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pulses();
    return {permit_o, erase_o, pass_o, reject_o};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic prefix(input logic [AW-1:0] hi);
    wr(hi | 17'h05555, 8'hAA);
    wr(hi | 17'h02AAA, 8'h55);
  endtask

  task automatic short_cmd(input logic [7:0] c);
    prefix(17'h0);
    wr(17'h05555, c);
  endtask

  task automatic long_cmd(input logic [7:0] c);
    short_cmd(8'h80);
    prefix(17'h0);
    wr(17'h05555, c);
  endtask

  task automatic t_reset();
    chk("R1 prot", prot_en_o, 0);
    chk("R1 idmode", id_mode_o, 0);
    chk("R1 locked", locked_o, 0);
    chk("R1 pulses", pulses(), 0);
  endtask

  task automatic t_plain_pass();
    wr(17'h00123, 8'h3C);
    chk("R8 pass on plain write", pulses(), 4'b0010);
    @(negedge clk);
    chk("R11 pulse one cycle", pulses(), 0);
  endtask

  task automatic t_id();
    short_cmd(8'h90);
    chk("R6 id on short", id_mode_o, 1);
    chk("R6 no pulse", pulses(), 0);
    rd_addr = 17'h00000; #1;
    chk("R7 hit mfr", id_hit_o, 1);
    chk("R7 mfr byte", id_data_o, 8'hBF);
    rd_addr = 17'h00001; #1;
    chk("R7 dev byte", id_data_o, DEV);
    rd_addr = 17'h18001; #1;
    chk("R2 read high bits ignored", {id_hit_o, id_data_o}, {1'b1, DEV});
    rd_addr = 17'h00002; #1;
    chk("R7 other addr miss", id_hit_o, 0);
    short_cmd(8'hF0);
    chk("R6 id off", id_mode_o, 0);
    rd_addr = 17'h00000; #1;
    chk("R7 miss when off", id_hit_o, 0);
    long_cmd(8'h60);
    chk("R6 id on long", id_mode_o, 1);
    short_cmd(8'hF0);
    chk("R6 id off again", id_mode_o, 0);
  endtask

  task automatic t_permit();
    prefix(17'h18000);
    wr(17'h1D555, 8'hA0);
    chk("R3 R2 permit pulse", pulses(), 4'b1000);
    chk("R3 prot on", prot_en_o, 1);
    wr(17'h05555, 8'hAA);
    chk("R3 load passes key byte", pulses(), 4'b0010);
    wr(17'h00402, 8'h77);
    chk("R3 load passes data", pulses(), 4'b0010);
    @(negedge clk); page_done_i = 1'b1;
    @(negedge clk); page_done_i = 1'b0;
  endtask

  task automatic t_reject();
    wr(17'h00402, 8'h11);
    chk("R9 reject pulse", pulses(), 4'b0001);
    chk("R9 locked", locked_o, 1);
    repeat (LOCK - 1) @(negedge clk);
    chk("R9 still locked", locked_o, 1);
    @(negedge clk);
    chk("R9 lock ends", locked_o, 0);
  endtask

  task automatic t_locked_ignore();
    wr(17'h00010, 8'h22);
    chk("R9 second reject", pulses(), 4'b0001);
    short_cmd(8'h90);
    chk("R9 ignored id", id_mode_o, 0);
    chk("R9 ignored pulses", pulses(), 0);
    repeat (LOCK) @(negedge clk);
    chk("R9 unlocked", locked_o, 0);
  endtask

  task automatic t_erase();
    long_cmd(8'h10);
    chk("R5 erase pulse", pulses(), 4'b0100);
    chk("R5 prot kept", prot_en_o, 1);
  endtask

  task automatic t_unprot();
    long_cmd(8'h20);
    chk("R4 prot off", prot_en_o, 0);
    chk("R4 no pulse", pulses(), 0);
    wr(17'h00050, 8'h99);
    chk("R8 pass after unprotect", pulses(), 4'b0010);
  endtask

  task automatic t_mismatch();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h56);
    chk("R10 mismatch silent", pulses(), 0);
    wr(17'h05555, 8'hA0);
    chk("R10 restart from idle", pulses(), 4'b0010);
    chk("R10 prot unchanged", prot_en_o, 0);
    short_cmd(8'h80);
    prefix(17'h0);
    wr(17'h05555, 8'h30);
    chk("R10 unknown final byte", {pulses(), prot_en_o, id_mode_o}, 0);
    wr(17'h04555, 8'hAA);
    chk("R2 low bits matter", pulses(), 4'b0010);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    page_done_i = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_pass();
    t_id();
    t_permit();
    t_reject();
    t_locked_ignore();
    t_erase();
    t_unprot();
    t_mismatch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule